// File: doc/BRIEF.md
# Seconds Counter with Alarm Flags

This block is a register-mapped seconds counter. An external prescaler supplies a tick pulse once per second. While the block is enabled and its time is valid, each tick adds one to a seconds count. Software programs an alarm compare value. The alarm flag is raised when the count moves on from a value equal to the compare value, so the alarm lands one second after equality. When the count wraps past its top value, an overflow flag is raised and counting stops.

Flags are never cleared by writing ones to the status word. Each flag is cleared as a side effect of writing a data register. Loading the seconds register clears the invalid-time and overflow flags. Writing the compare register clears the alarm flag. A software-reset bit in the control register forces every other register to its default value. Per-source enables combine the alarm and overflow flags into one interrupt line.

Top module: `secs_alarm_ctr`

## Requirements
- R1: With count-enable set and neither invalid-time nor overflow set, each tick pulse adds exactly one to the seconds value. Without an increment or an accepted load, the value holds.
- R2: A write to the seconds register loads it only while count-enable is clear. With count-enable set, the write changes nothing, including the flags.
- R3: The alarm flag sets when an increment starts from a seconds value equal to the alarm register. Equality on its own never sets it.
- R4: Any write to the alarm register stores the value and clears the alarm flag. A clear wins over a set in the same cycle.
- R5: An accepted seconds load clears both the invalid-time flag and the overflow flag.
- R6: After reset the invalid-time flag is set. An increment from the all-ones value gives zero and sets the overflow flag. While either flag is set, ticks do not increment.
- R7: Writing 1 to control bit 0 immediately returns every other register to its default: seconds 0, alarm 0, count-enable 0, invalid 1, overflow 0, alarm flag 0, enables 0. The block stays held in that state, ignoring other writes, until control bit 0 is written with 0.
- R8: Interrupt-enable bit 0 gates the alarm flag and bit 1 gates the overflow flag. `irq` is the OR of the two gated flags.
- R9: A tick in the same cycle as a write to the seconds or status register produces no increment.
- R10: A read returns on `rdata` one cycle after `rd_en`, and the value holds until the next read. Word addresses are: 0 seconds, 1 alarm, 2 status, 3 control, 4 interrupt enable. Other addresses read 0.
- R11: Status bits are: 0 count-enable (the only writable bit), 1 invalid-time, 2 overflow, 3 alarm flag. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse from the 1 Hz prescaler |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Word address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench targets several boundary cases.
- The alarm boundary: a design that compares on equality raises its flag a second early.
- The wrap from all-ones: a design that does not stall afterwards keeps counting from zero.
- A load attempted while counting: a design that does not guard it lets software corrupt the time or clear the invalid flag.
- A tick coinciding with a register write: a design that gives the tick priority gains an extra second.
- Soft reset: the bench checks that writes are locked out while the reset bit is held.

Random traffic with loads near the top value and alarms near the count is compared against a bench model on every read and every cycle of `irq`.

// File: rtl/secs_pkg.sv
package secs_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_SEC  = 3'd0;
  localparam logic [ADDR_W-1:0] A_ALM  = 3'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd2;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd3;
  localparam logic [ADDR_W-1:0] A_IEN  = 3'd4;

  localparam int ST_EN  = 0;
  localparam int ST_INV = 1;
  localparam int ST_OVF = 2;
  localparam int ST_ALM = 3;

  localparam int IE_ALM = 0;
  localparam int IE_OVF = 1;

  function automatic logic [DATA_W-1:0] pack_status(input logic en, input logic inv,
                                                    input logic ovf, input logic alm);
    logic [DATA_W-1:0] s;
    s = '0;
    s[ST_EN]  = en;
    s[ST_INV] = inv;
    s[ST_OVF] = ovf;
    s[ST_ALM] = alm;
    return s;
  endfunction
endpackage

// File: rtl/secs_bus.sv
module secs_bus
  import secs_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        wbits,
  input  logic [CNT_W-1:0]  sec_q,
  input  logic [CNT_W-1:0]  alarm_q,
  input  logic              inval_q,
  input  logic              ovf_q,
  input  logic              alarm_f_q,
  output logic              srst_q,
  output logic              srst_act,
  output logic              count_en_q,
  output logic [1:0]        ien_q,
  output logic              sec_wr,
  output logic              alm_wr,
  output logic              stat_wr,
  output logic [DATA_W-1:0] rdata
);
  logic ctrl_wr;
  logic ien_wr;

  // write strobes per register
  assign sec_wr   = wr_en && (addr == A_SEC);
  assign alm_wr   = wr_en && (addr == A_ALM);
  assign stat_wr  = wr_en && (addr == A_STAT);
  assign ctrl_wr  = wr_en && (addr == A_CTRL);
  assign ien_wr   = wr_en && (addr == A_IEN);

  // soft reset acts in the cycle it is written, then holds while the bit stays set
  assign srst_act = srst_q || (ctrl_wr && wbits[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       srst_q <= 1'b0;
    else if (ctrl_wr) srst_q <= wbits[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_en_q <= 1'b0;
      ien_q      <= '0;
    end else if (srst_act) begin
      count_en_q <= 1'b0;
      ien_q      <= '0;
    end else begin
      if (stat_wr) count_en_q <= wbits[ST_EN];
      if (ien_wr)  ien_q      <= wbits;
    end
  end

  function automatic logic [DATA_W-1:0] rd_sel(input logic [ADDR_W-1:0] a);
    logic [DATA_W-1:0] v;
    case (a)
      A_SEC:   v = DATA_W'(sec_q);
      A_ALM:   v = DATA_W'(alarm_q);
      A_STAT:  v = pack_status(count_en_q, inval_q, ovf_q, alarm_f_q);
      A_CTRL:  v = DATA_W'(srst_q);
      A_IEN:   v = DATA_W'(ien_q);
      default: v = '0;
    endcase
    return v;
  endfunction

  // registered read port: value held until the next read strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (rd_en)  rdata <= rd_sel(addr);
  end
endmodule

// File: rtl/secs_core.sv
module secs_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srst_act,
  input  logic             tick,
  input  logic             count_en,
  input  logic             sec_wr,
  input  logic             stat_wr,
  input  logic             alm_wr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] sec_q,
  output logic [CNT_W-1:0] alarm_q,
  output logic             inval_q,
  output logic             ovf_q,
  output logic             alarm_f_q,
  output logic             inc_ev,
  output logic             sec_wr_acc,
  output logic             wrap_ev,
  output logic             alarm_ev
);
  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] x);
    return x + CNT_W'(1);
  endfunction

  function automatic logic at_top(input logic [CNT_W-1:0] x);
    return &x;
  endfunction

  function automatic logic may_count(input logic en, input logic inv, input logic ovf);
    return en && !inv && !ovf;
  endfunction

  // a bus write to seconds or status in the tick cycle takes priority
  assign inc_ev     = tick && may_count(count_en, inval_q, ovf_q) && !srst_act
                      && !sec_wr && !stat_wr;
  assign sec_wr_acc = sec_wr && !count_en && !srst_act;
  assign wrap_ev    = inc_ev && at_top(sec_q);
  assign alarm_ev   = inc_ev && (sec_q == alarm_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q   <= '0;
      inval_q <= 1'b1;
      ovf_q   <= 1'b0;
    end else if (srst_act) begin
      sec_q   <= '0;
      inval_q <= 1'b1;
      ovf_q   <= 1'b0;
    end else if (sec_wr_acc) begin
      sec_q   <= wdata;
      inval_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else if (inc_ev) begin
      sec_q <= next_count(sec_q);
      if (wrap_ev) ovf_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_q   <= '0;
      alarm_f_q <= 1'b0;
    end else if (srst_act) begin
      alarm_q   <= '0;
      alarm_f_q <= 1'b0;
    end else if (alm_wr) begin
      alarm_q   <= wdata;
      alarm_f_q <= 1'b0;
    end else if (alarm_ev) begin
      alarm_f_q <= 1'b1;
    end
  end
endmodule

// File: rtl/secs_irq.sv
module secs_irq
  import secs_pkg::*;
(
  input  logic       alarm_f,
  input  logic       ovf,
  input  logic [1:0] ien,
  output logic       irq
);
  logic [1:0] src;
  assign src[IE_ALM] = alarm_f;
  assign src[IE_OVF] = ovf;
  assign irq = |(src & ien);
endmodule

// File: rtl/secs_alarm_ctr.sv
module secs_alarm_ctr
  import secs_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic             srst_q, srst_act, count_en_q;
  logic [1:0]       ien_q;
  logic             sec_wr, alm_wr, stat_wr;
  logic [CNT_W-1:0] sec_q, alarm_q;
  logic             inval_q, ovf_q, alarm_f_q;
  logic             inc_ev, sec_wr_acc, wrap_ev, alarm_ev;

  secs_bus #(.CNT_W(CNT_W)) u_bus (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wbits(wdata[1:0]), .sec_q(sec_q), .alarm_q(alarm_q), .inval_q(inval_q),
    .ovf_q(ovf_q), .alarm_f_q(alarm_f_q), .srst_q(srst_q), .srst_act(srst_act),
    .count_en_q(count_en_q), .ien_q(ien_q), .sec_wr(sec_wr), .alm_wr(alm_wr),
    .stat_wr(stat_wr), .rdata(rdata)
  );

  secs_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .srst_act(srst_act), .tick(tick),
    .count_en(count_en_q), .sec_wr(sec_wr), .stat_wr(stat_wr), .alm_wr(alm_wr),
    .wdata(wdata[CNT_W-1:0]), .sec_q(sec_q), .alarm_q(alarm_q), .inval_q(inval_q),
    .ovf_q(ovf_q), .alarm_f_q(alarm_f_q), .inc_ev(inc_ev), .sec_wr_acc(sec_wr_acc),
    .wrap_ev(wrap_ev), .alarm_ev(alarm_ev)
  );

  secs_irq u_irq (
    .alarm_f(alarm_f_q), .ovf(ovf_q), .ien(ien_q), .irq(irq)
  );
endmodule

// File: rtl/secs_chk.sv
module secs_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             rd_en,
  input logic [31:0]      rdata,
  input logic             irq,
  input logic             srst_act,
  input logic             count_en_q,
  input logic [1:0]       ien_q,
  input logic             sec_wr,
  input logic             stat_wr,
  input logic             alm_wr,
  input logic [CNT_W-1:0] sec_q,
  input logic [CNT_W-1:0] alarm_q,
  input logic             inval_q,
  input logic             ovf_q,
  input logic             alarm_f_q,
  input logic             inc_ev,
  input logic             sec_wr_acc,
  input logic             wrap_ev
);
  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_ev && !sec_wr_acc && !srst_act) |=> $stable(sec_q));

  assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_ev && !srst_act && !(&sec_q)) |=> (sec_q == $past(sec_q) + CNT_W'(1)));

  assert_ignore_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_wr && count_en_q && !srst_act) |=> ($stable(sec_q) && $stable(inval_q)));

  assert_alarm_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_f_q) |-> $past(inc_ev && (sec_q == alarm_q)));

  assert_alarm_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    alm_wr |=> !alarm_f_q);

  assert_load_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sec_wr_acc |=> (!inval_q && !ovf_q));

  assert_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (inval_q || ovf_q) |-> !inc_ev);

  assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_ev |=> (ovf_q && (sec_q == '0)));

  assert_srst_R7: assert property (@(posedge clk) disable iff (!rst_n)
    srst_act |=> ((sec_q == '0) && (alarm_q == '0) && inval_q && !ovf_q
                  && !alarm_f_q && !count_en_q && (ien_q == 2'b00)));

  assert_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq == ((alarm_f_q && ien_q[0]) || (ovf_q && ien_q[1])));

  assert_tick_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (sec_wr || stat_wr)) |-> !inc_ev);

  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

bind secs_alarm_ctr secs_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .rd_en(rd_en), .rdata(rdata), .irq(irq),
  .srst_act(srst_act), .count_en_q(count_en_q), .ien_q(ien_q), .sec_wr(sec_wr),
  .stat_wr(stat_wr), .alm_wr(alm_wr), .sec_q(sec_q), .alarm_q(alarm_q),
  .inval_q(inval_q), .ovf_q(ovf_q), .alarm_f_q(alarm_f_q), .inc_ev(inc_ev),
  .sec_wr_acc(sec_wr_acc), .wrap_ev(wrap_ev)
);

// File: tb/sim_secs_alarm_ctr.sv
module sim_secs_alarm_ctr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model of the register state
  logic [31:0] m_sec, m_alm;
  logic        m_en, m_inv, m_ovf, m_af, m_srst;
  logic [1:0]  m_ie;

  always #2 clk = ~clk;

  secs_alarm_ctr u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
                     .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_sec;
      3'd1: return m_alm;
      3'd2: return {28'd0, m_af, m_ovf, m_inv, m_en};
      3'd3: return {31'd0, m_srst};
      3'd4: return {30'd0, m_ie};
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic m_irq();
    return (m_af && m_ie[0]) || (m_ovf && m_ie[1]);
  endfunction

  task automatic m_reset();
    m_sec = 0; m_alm = 0; m_en = 0; m_inv = 1; m_ovf = 0; m_af = 0; m_ie = 0;
  endtask

  task automatic m_update(input bit w, input logic [2:0] a, input logic [31:0] d,
                          input bit t);
    bit act, inc, acc, hit, wrp;
    act = m_srst || (w && a == 3'd3 && d[0]);
    inc = t && m_en && !m_inv && !m_ovf && !act && !(w && (a == 3'd0 || a == 3'd2));
    acc = w && a == 3'd0 && !m_en && !act;
    hit = inc && (m_sec == m_alm);
    wrp = inc && (m_sec == 32'hFFFF_FFFF);
    if (w && a == 3'd3) m_srst = d[0];
    if (act) m_reset();
    else begin
      if (w && a == 3'd2) m_en = d[0];
      if (w && a == 3'd4) m_ie = d[1:0];
      if (acc) begin m_sec = d; m_inv = 0; m_ovf = 0; end
      else if (inc) begin m_sec = m_sec + 1; if (wrp) m_ovf = 1; end
      if (w && a == 3'd1) begin m_alm = d; m_af = 0; end
      else if (hit) m_af = 1;
    end
  endtask

  // one bus cycle; checks a read against the model and irq every cycle
  task automatic step(input bit w, input bit r, input logic [2:0] a,
                      input logic [31:0] d, input bit t, input string req);
    logic [31:0] exp;
    exp = m_read(a);
    wr_en = w; rd_en = r; addr = a; wdata = d; tick = t;
    @(posedge clk);
    m_update(w, a, d, t);
    #1;
    wr_en = 0; rd_en = 0; tick = 0;
    if (r) chk(rdata === exp, req, rdata, exp);
    chk(irq === m_irq(), "R8 irq", {31'd0, irq}, {31'd0, m_irq()});
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input string req);
    step(1, 0, a, d, 0, req);
  endtask
  task automatic rd(input logic [2:0] a, input string req);
    step(0, 1, a, 0, 0, req);
  endtask
  task automatic tk(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 1, "R1 tick");
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    m_reset(); m_srst = 0;
    void'($urandom(32'd20240611));
    #7 rst_n = 1'b1;
    @(negedge clk);

    rd(3'd2, "R6 status after reset");
    chk(rdata === 32'h2, "R6 invalid set after reset", rdata, 32'h2);
    rd(3'd0, "R1 seconds after reset");

    wr(3'd2, 32'h1, "R11 enable");
    tk(3);
    rd(3'd0, "R6 stall while invalid");
    chk(rdata === 32'd0, "R6 no count while invalid", rdata, 32'd0);

    wr(3'd0, 32'd77, "R2 load while counting");
    rd(3'd2, "R2 status");
    chk(rdata === 32'h3, "R2 ignored write keeps invalid", rdata, 32'h3);

    wr(3'd2, 32'h0, "R11 disable");
    wr(3'd0, 32'd100, "R5 load");
    rd(3'd2, "R5 status");
    chk(rdata === 32'h0, "R5 load clears invalid", rdata, 32'h0);

    wr(3'd1, 32'd102, "R4 alarm");
    wr(3'd4, 32'h1, "R8 enable alarm irq");
    wr(3'd2, 32'h1, "R11 enable");
    tk(2);
    rd(3'd2, "R3 status at equality");
    chk(rdata === 32'h1, "R3 equality alone no flag", rdata, 32'h1);
    tk(1);
    rd(3'd0, "R1 seconds");
    chk(rdata === 32'd103, "R1 three ticks", rdata, 32'd103);
    rd(3'd2, "R3 status after increment");
    chk(rdata === 32'h9, "R3 flag after increment", rdata, 32'h9);
    chk(irq === 1'b1, "R8 alarm irq", {31'd0, irq}, 32'd1);

    wr(3'd1, 32'd200, "R4 rewrite alarm");
    rd(3'd2, "R4 status");
    chk(rdata === 32'h1, "R4 flag cleared", rdata, 32'h1);

    step(1, 0, 3'd2, 32'h1, 1, "R9 tick with status write");
    rd(3'd0, "R9 seconds");
    chk(rdata === 32'd103, "R9 tick dropped", rdata, 32'd103);

    step(0, 0, 3'd0, 0, 0, "R10 idle");
    step(0, 0, 3'd0, 0, 0, "R10 idle");
    chk(rdata === 32'd103, "R10 read data held", rdata, 32'd103);
    rd(3'd0, "R10 second read");
    chk(rdata === 32'd103, "R10 repeated read", rdata, 32'd103);

    wr(3'd2, 32'h0, "R11 disable");
    wr(3'd0, 32'hFFFF_FFFE, "R5 load near top");
    wr(3'd4, 32'h2, "R8 overflow irq");
    wr(3'd2, 32'h1, "R11 enable");
    tk(2);
    rd(3'd0, "R6 wrapped");
    chk(rdata === 32'd0, "R6 wrap to zero", rdata, 32'd0);
    rd(3'd2, "R6 status overflow");
    chk(rdata === 32'h5, "R6 overflow flag", rdata, 32'h5);
    chk(irq === 1'b1, "R8 overflow irq", {31'd0, irq}, 32'd1);
    tk(2);
    rd(3'd0, "R6 stall after overflow");
    chk(rdata === 32'd0, "R6 no count after overflow", rdata, 32'd0);

    wr(3'd3, 32'h1, "R7 assert soft reset");
    rd(3'd2, "R7 status");
    chk(rdata === 32'h2, "R7 defaults", rdata, 32'h2);
    wr(3'd0, 32'd5, "R7 write during reset");
    wr(3'd4, 32'h3, "R7 write during reset");
    rd(3'd0, "R7 seconds held");
    rd(3'd4, "R7 enables held");
    chk(rdata === 32'h0, "R7 enables stay default", rdata, 32'h0);
    rd(3'd3, "R7 control reads 1");
    wr(3'd3, 32'h0, "R7 release");
    wr(3'd0, 32'd9, "R7 load after release");
    rd(3'd0, "R7 load works after release");
    chk(rdata === 32'd9, "R7 released", rdata, 32'd9);
    rd(3'd6, "R10 unmapped address");

    for (int i = 0; i < 4000; i++) begin
      bit w, r, t;
      logic [2:0] a;
      logic [31:0] d;
      int sel;
      w = ($urandom % 10) < 3;
      r = ($urandom % 10) < 4;
      t = ($urandom % 2) == 1;
      a = 3'($urandom % 6);
      sel = $urandom % 4;
      d = (sel == 0) ? $urandom :
          (sel == 1) ? 32'hFFFF_FFF0 + ($urandom % 16) :
          (sel == 2) ? m_sec + ($urandom % 4) : ($urandom % 4);
      if (a == 3'd3) d = {31'd0, ($urandom % 8) == 0};
      if (w && a == 3'd3 && !d[0] && m_srst == 0) d = 0;
      step(w, r, a, d, t, "R10 random read");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule